// File: doc/BRIEF.md
# Packed Conversion Fault Prioritizer

This block settles, for one execution of a packed integer-to-float conversion instruction, which fault is taken, if any. A fault is either taken or the result is allowed to commit. The block also owns the switch of the shared register file from stack-based floating-point mode into packed-integer mode. Each evaluation is started by a one-cycle valid strobe. The strobe carries the emulation and task-switched control bits, a flag that says whether the source operand comes from memory or from a register, the limit-violation and page-fault indications of the memory path, a flag for a pending legacy floating-point fault, and the inexact-result flag together with its mask bit.

The result is registered on the strobe and held until the next strobe. It is a one-hot fault code in which one bit means "no fault, commit".

A register-source execution that passes the emulation, task-switched and pending-fault checks switches the register file into packed-integer mode if it is still in floating-point mode. In the cycle after the strobe, the block gives a one-cycle transition pulse and a per-register exponent-fill mask, and it updates the stack top and the tag state. The numeric check comes after the switch. The switch and a precision fault can therefore belong to the same evaluation.

A memory-source execution never touches the mode.

Top module: `pcvt_fault_arbiter`

## Requirements
- R1: `fault_o` is 7 bits wide and exactly one bit of it is set at all times. The bit positions are: 0 none, 1 invalid opcode, 2 device not available, 3 limit violation (stack or protection), 4 page fault, 5 pending legacy math fault, 6 SIMD precision fault. Bit 0 is set when no condition is active.
- R2: When `emul_i` is 1, the result is the invalid-opcode fault (bit 1) for either operand source, whatever the other inputs are.
- R3: When `emul_i` is 0 and `task_sw_i` is 1, the result is the device-not-available fault (bit 2) for either operand source.
- R4: With a memory source (`mem_src_i`=1), a limit violation (bit 3) ranks above a page fault (bit 4), and both rank above the precision fault. With a register source, `limit_viol_i` and `page_flt_i` have no effect.
- R5: With a register source, a pending legacy fault (`fp_pend_i`) gives the math fault (bit 5) and blocks the mode switch. With a memory source, `fp_pend_i` has no effect.
- R6: A register-source evaluation with no invalid-opcode, device-not-available or math fault, made while the mode is floating-point, performs the mode switch. In the cycle after the strobe, `transition_o` is 1 for one cycle, `exp_fill_o` is all ones for that cycle, `stack_top_o` becomes 0, `tags_o` becomes all ones (1 = valid) and `mode_pkd_o` becomes 1. No switch happens when the mode is already packed.
- R7: A memory-source evaluation never raises `transition_o` or `exp_fill_o`, and it never changes `stack_top_o`, `tags_o` or `mode_pkd_o`.
- R8: The precision fault (bit 6) has the lowest priority. It is raised when `inexact_i`=1 and `inexact_mask_i`=0 and no higher fault is present. For a register source it may be raised in the same evaluation as the mode switch.
- R9: When the numeric check is reached with `inexact_i`=1 and `inexact_mask_i`=1, no fault is raised and `prec_sticky_o` is set. It then stays set until reset. A higher fault keeps it unchanged.
- R10: Results are registered on the edge where `eval_i` is 1. Between strobes, `fault_o` holds its value, and `transition_o` and `exp_fill_o` stay 0.
- R11: Reset gives `fault_o` = none, `stack_top_o` = 0, `tags_o` = 0 (all empty), `mode_pkd_o` = 0 (floating-point), `prec_sticky_o` = 0 and `transition_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | Valid strobe: evaluate one execution |
| emul_i | input | 1 | Emulation control bit |
| task_sw_i | input | 1 | Task-switched control bit |
| mem_src_i | input | 1 | 1 = memory source operand, 0 = register source |
| limit_viol_i | input | 1 | Segment limit violation on the memory access |
| page_flt_i | input | 1 | Page fault on the memory access |
| fp_pend_i | input | 1 | Legacy floating-point fault pending |
| inexact_i | input | 1 | Conversion result is inexact |
| inexact_mask_i | input | 1 | Precision exception mask |
| fault_o | output | 7 | One-hot fault code |
| transition_o | output | 1 | One-cycle mode-switch pulse |
| exp_fill_o | output | 8 | Per-register strobe: write ones to exponent field |
| stack_top_o | output | 3 | Stack top pointer |
| tags_o | output | 8 | Register tags, 1 = valid |
| mode_pkd_o | output | 1 | 1 = packed-integer mode |
| prec_sticky_o | output | 1 | Sticky masked-precision status |

## Verification
The mode switch and the precision fault can fall in the same cycle. This happens for a register-source evaluation in floating-point mode with the inexact flag set and unmasked. The bench provokes it with directed evaluations after a reset, and again from random streams that include resets. It judges the case by expecting bit 6 in `fault_o` together with a `transition_o` pulse, a zero stack top and all tags valid in the same cycle. A second case sets the mask, so that the switch and the sticky bit must appear together with the "none" code.

// File: rtl/pcvt_pkg.sv
package pcvt_pkg;
  localparam int NREG   = 8;
  localparam int TOP_W  = $clog2(NREG);
  localparam int NCOND  = 6;
  localparam int FLT_W  = NCOND + 1;
  // one-hot fault bit positions (0 = commit)
  localparam int F_NONE = 0;
  localparam int F_UD   = 1;
  localparam int F_NM   = 2;
  localparam int F_LIM  = 3;
  localparam int F_PF   = 4;
  localparam int F_MF   = 5;
  localparam int F_XM   = 6;

  typedef struct packed {
    logic emul;
    logic task_sw;
    logic mem_src;
    logic limit_viol;
    logic page_flt;
    logic fp_pend;
    logic inexact;
    logic inexact_mask;
  } pcvt_cond_t;
endpackage

// File: rtl/pcvt_prio_pick.sv
// Fixed-priority one-hot picker: bit 0 is the highest priority.
module pcvt_prio_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  for (genvar i = 0; i < N; i++) begin : g_pick
    if (i == 0) begin : g_top
      assign grant_o[i] = req_i[i];
    end else begin : g_rest
      assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/pcvt_cond_decode.sv
// Turns the raw conditions into a ranked request vector, ordered
// invalid-opcode, device-not-available, limit, page, math, precision.
module pcvt_cond_decode
  import pcvt_pkg::*;
(
  input  pcvt_cond_t       cond_i,
  input  logic             mode_pkd_i,
  output logic [NCOND-1:0] req_o,
  output logic             do_switch_o,
  output logic             sticky_set_o
);
  logic higher_clear;
  logic reg_src;

  always_comb begin
    reg_src   = ~cond_i.mem_src;
    req_o     = '0;
    req_o[F_UD-1]  = cond_i.emul;
    req_o[F_NM-1]  = cond_i.task_sw;
    req_o[F_LIM-1] = cond_i.mem_src & cond_i.limit_viol;
    req_o[F_PF-1]  = cond_i.mem_src & cond_i.page_flt;
    req_o[F_MF-1]  = reg_src & cond_i.fp_pend;
    req_o[F_XM-1]  = cond_i.inexact & ~cond_i.inexact_mask;
    // the numeric stage is reached only if every higher slot is quiet
    higher_clear  = ~(|req_o[F_MF-1:0]);
    do_switch_o   = reg_src & higher_clear & ~mode_pkd_i;
    sticky_set_o  = higher_clear & cond_i.inexact & cond_i.inexact_mask;
  end
endmodule

// File: rtl/pcvt_mode_ctl.sv
// Holds the register-file mode, stack top and tags; performs the switch.
module pcvt_mode_ctl
  import pcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_i,
  input  logic             do_switch_i,
  output logic             mode_pkd_o,
  output logic [TOP_W-1:0] top_o,
  output logic [NREG-1:0]  tags_o,
  output logic             switch_o,
  output logic [NREG-1:0]  exp_fill_o
);
  logic             mode_d, mode_q;
  logic [TOP_W-1:0] top_d, top_q;
  logic [NREG-1:0]  tags_d, tags_q;
  logic             sw_d, sw_q;
  logic             take;

  always_comb begin
    take   = eval_i & do_switch_i;
    mode_d = mode_q;
    top_d  = top_q;
    tags_d = tags_q;
    sw_d   = take;
    if (take) begin
      mode_d = 1'b1;
      top_d  = '0;
      tags_d = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      top_q  <= '0;
      tags_q <= '0;
      sw_q   <= 1'b0;
    end else begin
      sw_q <= sw_d;
      if (take) begin
        mode_q <= mode_d;
        top_q  <= top_d;
        tags_q <= tags_d;
      end
    end
  end

  assign mode_pkd_o = mode_q;
  assign top_o      = top_q;
  assign tags_o     = tags_q;
  assign switch_o   = sw_q;
  assign exp_fill_o = {NREG{sw_q}};

  // R6: a pulse always shows the switched register-file state
  a_r6_switch_state: assert property (@(posedge clk) disable iff (!rst_n)
    switch_o |-> (top_o == '0) && (&tags_o) && mode_pkd_o);
  // R6: no switch is requested when the mode is already packed
  a_r6_once_only: assert property (@(posedge clk) disable iff (!rst_n)
    mode_pkd_o |=> !switch_o);
endmodule

// File: rtl/pcvt_fault_arbiter.sv
module pcvt_fault_arbiter
  import pcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_i,
  input  logic             emul_i,
  input  logic             task_sw_i,
  input  logic             mem_src_i,
  input  logic             limit_viol_i,
  input  logic             page_flt_i,
  input  logic             fp_pend_i,
  input  logic             inexact_i,
  input  logic             inexact_mask_i,
  output logic [FLT_W-1:0] fault_o,
  output logic             transition_o,
  output logic [NREG-1:0]  exp_fill_o,
  output logic [TOP_W-1:0] stack_top_o,
  output logic [NREG-1:0]  tags_o,
  output logic             mode_pkd_o,
  output logic             prec_sticky_o
);
  pcvt_cond_t       cond;
  logic [NCOND-1:0] req, grant;
  logic             any_req, do_switch, sticky_set;
  logic [FLT_W-1:0] fault_d, fault_q;
  logic             sticky_d, sticky_q;

  always_comb begin
    cond.emul         = emul_i;
    cond.task_sw      = task_sw_i;
    cond.mem_src      = mem_src_i;
    cond.limit_viol   = limit_viol_i;
    cond.page_flt     = page_flt_i;
    cond.fp_pend      = fp_pend_i;
    cond.inexact      = inexact_i;
    cond.inexact_mask = inexact_mask_i;
  end

  pcvt_cond_decode u_dec (
    .cond_i      (cond),
    .mode_pkd_i  (mode_pkd_o),
    .req_o       (req),
    .do_switch_o (do_switch),
    .sticky_set_o(sticky_set)
  );

  pcvt_prio_pick #(.N(NCOND)) u_pick (
    .req_i  (req),
    .grant_o(grant),
    .any_o  (any_req)
  );

  pcvt_mode_ctl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_i     (eval_i),
    .do_switch_i(do_switch),
    .mode_pkd_o (mode_pkd_o),
    .top_o      (stack_top_o),
    .tags_o     (tags_o),
    .switch_o   (transition_o),
    .exp_fill_o (exp_fill_o)
  );

  always_comb begin
    fault_d  = {grant, ~any_req};
    sticky_d = sticky_q | sticky_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q  <= FLT_W'(1) << F_NONE;
      sticky_q <= 1'b0;
    end else if (eval_i) begin
      fault_q  <= fault_d;
      sticky_q <= sticky_d;
    end
  end

  assign fault_o       = fault_q;
  assign prec_sticky_o = sticky_q;

  // R1: exactly one code bit
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(fault_o));
  // R2: emulation bit wins
  a_r2_emul_first: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i && emul_i |=> fault_o[F_UD]);
  // R5: pending math fault blocks the switch
  a_r5_mf_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i && !mem_src_i && fp_pend_i && !emul_i && !task_sw_i
    |=> fault_o[F_MF] && !transition_o);
  // R7: memory source never switches
  a_r7_mem_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i && mem_src_i |=> !transition_o && $stable(tags_o) && $stable(stack_top_o));
  // R10: result held between strobes
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> $stable(fault_o) && !transition_o);
  // R9: sticky never falls outside reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    prec_sticky_o |=> prec_sticky_o);
endmodule

// File: tb/test_pcvt_fault_arbiter.sv
module test_pcvt_fault_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eval_i = 1'b0, emul_i = 1'b0, task_sw_i = 1'b0, mem_src_i = 1'b0;
  logic limit_viol_i = 1'b0, page_flt_i = 1'b0, fp_pend_i = 1'b0;
  logic inexact_i = 1'b0, inexact_mask_i = 1'b0;
  logic [6:0] fault_o;
  logic       transition_o, mode_pkd_o, prec_sticky_o;
  logic [7:0] exp_fill_o, tags_o;
  logic [2:0] stack_top_o;

  int tests = 0, fails = 0;
  bit done = 0;
  // reference model state
  bit m_pkd = 0, m_sticky = 0;
  logic [6:0] m_fault = 7'b1;

  always #10 clk = ~clk;

  pcvt_fault_arbiter i_pcvt_fault_arbiter (
    .clk, .rst_n, .eval_i, .emul_i, .task_sw_i, .mem_src_i, .limit_viol_i,
    .page_flt_i, .fp_pend_i, .inexact_i, .inexact_mask_i, .fault_o,
    .transition_o, .exp_fill_o, .stack_top_o, .tags_o, .mode_pkd_o,
    .prec_sticky_o);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_fault(logic [7:0] c);
    // c = {emul,ts,mem,lim,pf,pend,inx,msk}
    if (c[7]) return 7'b0000010;
    if (c[6]) return 7'b0000100;
    if (c[5] && c[4]) return 7'b0001000;
    if (c[5] && c[3]) return 7'b0010000;
    if (!c[5] && c[2]) return 7'b0100000;
    if (c[1] && !c[0]) return 7'b1000000;
    return 7'b0000001;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    eval_i = 1'b0;
    @(negedge clk);
    m_pkd = 0; m_sticky = 0; m_fault = 7'b1;
    chk("R11 fault", fault_o, 7'b1);
    chk("R11 top", stack_top_o, 0);
    chk("R11 tags", tags_o, 0);
    chk("R11 mode", mode_pkd_o, 0);
    chk("R11 sticky", prec_sticky_o, 0);
    chk("R11 trans", transition_o, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_eval(string tag, logic [7:0] c);
    bit sw, reached;
    logic [7:0] tags_before;
    logic [2:0] top_before;
    @(negedge clk);
    {emul_i, task_sw_i, mem_src_i, limit_viol_i, page_flt_i, fp_pend_i,
     inexact_i, inexact_mask_i} = c;
    eval_i = 1'b1;
    tags_before = tags_o;
    top_before = stack_top_o;
    m_fault = exp_fault(c);
    reached = !c[7] && !c[6] && !(c[5] && (c[4] || c[3])) && !(!c[5] && c[2]);
    sw = reached && !c[5] && !m_pkd;
    if (reached && c[1] && c[0]) m_sticky = 1;
    @(negedge clk);
    eval_i = 1'b0;
    chk({tag, " fault"}, fault_o, m_fault);
    chk({tag, " R6 trans"}, transition_o, sw);
    chk({tag, " R6 expfill"}, exp_fill_o, sw ? 8'hFF : 8'h00);
    if (sw) m_pkd = 1;
    chk({tag, " R6 mode"}, mode_pkd_o, m_pkd);
    if (sw) begin
      chk({tag, " R6 top"}, stack_top_o, 0);
      chk({tag, " R6 tags"}, tags_o, 8'hFF);
    end else begin
      chk({tag, " R7 top"}, stack_top_o, top_before);
      chk({tag, " R7 tags"}, tags_o, tags_before);
    end
    chk({tag, " R9 sticky"}, prec_sticky_o, m_sticky);
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R10 hold", fault_o, m_fault);
    chk("R10 no pulse", transition_o, 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // c = {emul,ts,mem,lim,pf,pend,inx,msk}
    run_eval("R2 emul over all mem", 8'b11111110);
    run_eval("R2 emul over all reg", 8'b11011110);
    run_eval("R3 ts over lim", 8'b01111110);
    run_eval("R3 ts reg", 8'b01000100);
    idle_check();
    run_eval("R4 lim over pf", 8'b00111010);
    run_eval("R4 pf over xm", 8'b00101010);
    run_eval("R5 pend ignored mem", 8'b00100100);
    run_eval("R7 mem clean", 8'b00100000);
    run_eval("R4 lim ignored reg, R5 mf", 8'b00011100);
    run_eval("R1 none reg mf blocks", 8'b00000100);
    // switch and precision fault in the same evaluation
    run_eval("R8 R6 switch with xm", 8'b00000010);
    run_eval("R6 already packed", 8'b00000000);
    idle_check();
    do_reset();
    run_eval("R9 R6 switch with masked", 8'b00000011);
    run_eval("R9 masked under higher", 8'b01000011);
    do_reset();
    run_eval("R9 masked mem", 8'b00100011);
    run_eval("R1 none reg", 8'b00011000);
    for (int i = 0; i < 600; i++) begin
      logic [7:0] c;
      c = 8'($urandom);
      c[7] = ($urandom % 10) == 0;
      c[6] = ($urandom % 8) == 0;
      c[2] = ($urandom % 4) == 0;
      if (($urandom % 50) == 0) do_reset();
      run_eval("rand", c);
      if (($urandom % 4) == 0) idle_check();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule